// File: doc/BRIEF.md
# Trace buffer write controller

This block takes a stream of trace words and stores them, one full word per beat, into a memory region. The region starts at a base pointer and ends just before a 4KB-aligned limit address. A current write pointer tracks where the next word lands. When a write would reach the limit, the pointer goes back to the base pointer. What happens next depends on the buffer mode: the block can stop, keep going and raise an interrupt, or keep going quietly.

A trigger pulse is handled under a separate trigger mode. The block can stop after flushing, raise an interrupt and continue, or ignore the trigger. A stop first drains the single internal holding register to memory, then enters the stopped state and sets the sticky interrupt status. While stopped, the block accepts incoming words and throws them away. Software writes the status to zero, which clears the flag and resumes collection.

The unit has two enable bits. A tracing-context input picks which one applies: the self-hosted bit when the context input is high, the external bit when it is low. A disabled unit accepts and discards everything it is offered. Software can load the write pointer directly through a load strobe.

Top module: `tbuf_wr_ctrl`

## Requirements
- R1: The unit is enabled by `cfg_en_self` when `self_hosted` is 1, and by `cfg_en_ext` when `self_hosted` is 0. The other bit has no effect.
- R2: While the unit is disabled, `s_ready` is 1. Every offered word is consumed without any memory write.
- R3: Each accepted word is written to the current write pointer, with `m_strb` all ones. The pointer then advances by DATA_W/8 bytes.
- R4: The limit address is `cfg_limit_pg` shifted left by 12. When pointer plus DATA_W/8 is greater than or equal to the limit, the pointer reloads `cfg_base`.
- R5: Buffer mode 2'b00 (fill): a wrap stops collection and sets `irq_status`.
- R6: Buffer mode 2'b01 (wrap): a wrap sets `irq_status` and collection continues.
- R7: Buffer mode 2'b11 (circular): a wrap leaves `irq_status` unchanged and collection continues.
- R8: Trigger mode 2'b00: a trigger on a running, enabled unit does three things in order. It drains any pending word to memory, then enters the stopped state, then sets `irq_status`. While stopped, words are consumed and not written.
- R9: Trigger mode 2'b01: a trigger sets `irq_status` one cycle later, and collection continues.
- R10: Trigger mode 2'b11: a trigger has no effect on `irq_status` or on collection.
- R11: The reserved encoding 2'b10, in either mode field, behaves as the stop encoding 2'b00.
- R12: `irq_status` stays set until an `irq_clr` pulse. That pulse clears the flag and releases the stopped state. A set in the same cycle wins over the clear.
- R13: A `ptr_wr` pulse loads `ptr_wdata` into the write pointer. The next accepted word is written there.
- R14: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr` and `m_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Base pointer, the region start |
| cfg_limit_pg | input | ADDR_W-12 | Limit address bits above bit 11 |
| cfg_buf_mode | input | 2 | Buffer mode: 00 fill, 01 wrap, 11 circular, 10 as 00 |
| cfg_trg_mode | input | 2 | Trigger mode: 00 stop, 01 interrupt, 11 ignore, 10 as 00 |
| cfg_en_self | input | 1 | Enable used in the self-hosted context |
| cfg_en_ext | input | 1 | Enable used in the external context |
| self_hosted | input | 1 | Tracing context select |
| ptr_wr | input | 1 | Load strobe for the write pointer |
| ptr_wdata | input | ADDR_W | Write pointer load value |
| irq_clr | input | 1 | Software write of zero to the status flag |
| trigger | input | 1 | Trigger event pulse |
| s_valid | input | 1 | Trace word valid |
| s_data | input | DATA_W | Trace word |
| s_ready | output | 1 | Trace word consumed |
| m_valid | output | 1 | Memory write request |
| m_ready | input | 1 | Memory write accepted |
| m_addr | output | ADDR_W | Memory write byte address |
| m_data | output | DATA_W | Memory write data |
| m_strb | output | DATA_W/8 | Memory write byte strobes |
| irq_status | output | 1 | Sticky interrupt status |

## Verification
Four properties are checked on every cycle:
- a pending memory write holds steady under backpressure;
- a disabled unit keeps `s_ready` high and starts no new write;
- the status flag never drops without a clear;
- every write address is word aligned.

Other behaviour depends on a sequence of events, so only the bench scenarios can show it:
- the wrap point and the reload to base;
- the difference between fill, wrap and circular modes;
- the flush-before-stop ordering;
- the reserved-encoding fallback;
- the release of the stop by a clear.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_STOP  = 2'd2
    } run_state_e;

    // Mode field values shared by the buffer and trigger policies.
    localparam logic [1:0] MODE_STOP     = 2'b00;
    localparam logic [1:0] MODE_IRQ      = 2'b01;
    localparam logic [1:0] MODE_QUIET    = 2'b11;

endpackage

// File: rtl/tbuf_en_sel.sv
module tbuf_en_sel (
    input  logic self_hosted,
    input  logic en_self,
    input  logic en_ext,
    output logic unit_en
);
    always_comb begin
        if (self_hosted) begin
            unit_en = en_self;
        end else begin
            unit_en = en_ext;
        end
    end
endmodule

// File: rtl/tbuf_ptr_adv.sv
module tbuf_ptr_adv #(
    parameter int ADDR_W = 64,
    parameter int BYTES  = 8
) (
    input  logic [ADDR_W-1:0]    ptr,
    input  logic [ADDR_W-1:0]    base,
    input  logic [ADDR_W-13:0]   limit_pg,
    output logic [ADDR_W-1:0]    next_ptr,
    output logic                 wrap
);
    localparam int PAGE_BITS = 12;

    logic [ADDR_W:0] sum;
    logic [ADDR_W:0] limit_full;

    always_comb begin
        sum        = {1'b0, ptr} + (ADDR_W+1)'(BYTES);
        limit_full = {1'b0, limit_pg, {PAGE_BITS{1'b0}}};
        wrap       = (sum >= limit_full);
        next_ptr   = wrap ? base : sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/tbuf_policy.sv
module tbuf_policy
    import tbuf_pkg::*;
(
    input  logic [1:0] buf_mode,
    input  logic [1:0] trg_mode,
    input  logic       wrap_evt,
    input  logic       trg_evt,
    output logic       stop_req,
    output logic       irq_req
);
    logic buf_stop;
    logic trg_stop;

    always_comb begin
        // Bit 0 clear selects the stop behaviour (covers reserved 2'b10).
        buf_stop = (buf_mode[0] == 1'b0);
        trg_stop = (trg_mode[0] == 1'b0);
        stop_req = (wrap_evt && buf_stop) || (trg_evt && trg_stop);
        irq_req  = (wrap_evt && (buf_mode == MODE_IRQ)) ||
                   (trg_evt  && (trg_mode == MODE_IRQ));
    end
endmodule

// File: rtl/tbuf_wr_ctrl.sv
module tbuf_wr_ctrl
    import tbuf_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [ADDR_W-13:0]   cfg_limit_pg,
    input  logic [1:0]           cfg_buf_mode,
    input  logic [1:0]           cfg_trg_mode,
    input  logic                 cfg_en_self,
    input  logic                 cfg_en_ext,
    input  logic                 self_hosted,
    input  logic                 ptr_wr,
    input  logic [ADDR_W-1:0]    ptr_wdata,
    input  logic                 irq_clr,
    input  logic                 trigger,
    input  logic                 s_valid,
    input  logic [DATA_W-1:0]    s_data,
    output logic                 s_ready,
    output logic                 m_valid,
    input  logic                 m_ready,
    output logic [ADDR_W-1:0]    m_addr,
    output logic [DATA_W-1:0]    m_data,
    output logic [DATA_W/8-1:0]  m_strb,
    output logic                 irq_status
);
    localparam int BYTES = DATA_W / 8;

    typedef struct packed {
        run_state_e        state;
        logic [ADDR_W-1:0] ptr;
        logic              hold_vld;
        logic [ADDR_W-1:0] hold_addr;
        logic [DATA_W-1:0] hold_data;
        logic              irq;
    } ctrl_t;

    ctrl_t q, d;

    logic              unit_en;
    logic [ADDR_W-1:0] adv_ptr;
    logic              adv_wrap;
    logic              accept;
    logic              wrap_evt;
    logic              trg_evt;
    logic              stop_req;
    logic              irq_req;

    tbuf_en_sel u_en_sel (
        .self_hosted (self_hosted),
        .en_self     (cfg_en_self),
        .en_ext      (cfg_en_ext),
        .unit_en     (unit_en)
    );

    tbuf_ptr_adv #(
        .ADDR_W (ADDR_W),
        .BYTES  (BYTES)
    ) u_ptr_adv (
        .ptr      (q.ptr),
        .base     (cfg_base),
        .limit_pg (cfg_limit_pg),
        .next_ptr (adv_ptr),
        .wrap     (adv_wrap)
    );

    tbuf_policy u_policy (
        .buf_mode (cfg_buf_mode),
        .trg_mode (cfg_trg_mode),
        .wrap_evt (wrap_evt),
        .trg_evt  (trg_evt),
        .stop_req (stop_req),
        .irq_req  (irq_req)
    );

    always_comb begin
        // Ready: discard when disabled or stopped, store when running with room.
        s_ready = !unit_en || (q.state == ST_STOP) ||
                  ((q.state == ST_RUN) && (!q.hold_vld || m_ready));
        accept   = s_valid && s_ready && unit_en && (q.state == ST_RUN);
        wrap_evt = accept && adv_wrap;
        trg_evt  = trigger && unit_en && (q.state == ST_RUN);

        d = q;

        if (q.hold_vld && m_ready) begin
            d.hold_vld = 1'b0;
        end

        if (accept) begin
            d.hold_vld  = 1'b1;
            d.hold_addr = q.ptr;
            d.hold_data = s_data;
            d.ptr       = adv_ptr;
        end

        if (ptr_wr) begin
            d.ptr = ptr_wdata;
        end

        // Clear first so that any set in the same cycle takes priority.
        if (irq_clr) begin
            d.irq = 1'b0;
        end

        if (irq_req) begin
            d.irq = 1'b1;
        end

        unique case (q.state)
            ST_RUN: begin
                if (stop_req) begin
                    d.state = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (!d.hold_vld) begin
                    d.state = ST_STOP;
                    d.irq   = 1'b1;
                end
            end
            ST_STOP: begin
                if (irq_clr) begin
                    d.state = ST_RUN;
                end
            end
            default: begin
                d.state = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state     <= ST_RUN;
            q.ptr       <= '0;
            q.hold_vld  <= 1'b0;
            q.hold_addr <= '0;
            q.hold_data <= '0;
            q.irq       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign m_valid    = q.hold_vld;
    assign m_addr     = q.hold_addr;
    assign m_data     = q.hold_data;
    assign m_strb     = {BYTES{1'b1}};
    assign irq_status = q.irq;

endmodule

// File: rtl/tbuf_wr_ctrl_chk.sv
module tbuf_wr_ctrl_chk #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_en_self,
    input logic              cfg_en_ext,
    input logic              self_hosted,
    input logic              irq_clr,
    input logic              s_ready,
    input logic              m_valid,
    input logic              m_ready,
    input logic [ADDR_W-1:0] m_addr,
    input logic [DATA_W-1:0] m_data,
    input logic              irq_status
);
    localparam int OFS = $clog2(DATA_W / 8);

    logic en_port;
    assign en_port = self_hosted ? cfg_en_self : cfg_en_ext;

    // R14: a pending write holds under backpressure
    a_r14_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_data)));

    // R2: disabled unit consumes offered words
    a_r2_disabled_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !en_port |-> s_ready);

    // R2: disabled unit starts no new write
    a_r2_no_new_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_port && !m_valid) |=> !m_valid);

    // R12: status flag only drops after a clear
    a_r12_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status && !irq_clr) |=> irq_status);

    // R3: write addresses are word aligned
    a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (m_addr[OFS-1:0] == '0));

endmodule

bind tbuf_wr_ctrl tbuf_wr_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en_self (cfg_en_self),
    .cfg_en_ext  (cfg_en_ext),
    .self_hosted (self_hosted),
    .irq_clr     (irq_clr),
    .s_ready     (s_ready),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_addr      (m_addr),
    .m_data      (m_data),
    .irq_status  (irq_status)
);

// File: tb/tbuf_wr_ctrl_bench.sv
module tbuf_wr_ctrl_bench;
    localparam int ADDR_W = 64;
    localparam int DATA_W = 64;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [ADDR_W-1:0]   cfg_base = 64'h1000;
    logic [ADDR_W-13:0]  cfg_limit_pg = 52'h2;
    logic [1:0]          cfg_buf_mode = 2'b11;
    logic [1:0]          cfg_trg_mode = 2'b11;
    logic                cfg_en_self = 1'b0;
    logic                cfg_en_ext = 1'b0;
    logic                self_hosted = 1'b0;
    logic                ptr_wr = 1'b0;
    logic [ADDR_W-1:0]   ptr_wdata = '0;
    logic                irq_clr = 1'b0;
    logic                trigger = 1'b0;
    logic                s_valid = 1'b0;
    logic [DATA_W-1:0]   s_data = '0;
    logic                s_ready;
    logic                m_valid;
    logic                m_ready = 1'b1;
    logic [ADDR_W-1:0]   m_addr;
    logic [DATA_W-1:0]   m_data;
    logic [DATA_W/8-1:0] m_strb;
    logic                irq_status;

    int checks = 0;
    int errors = 0;
    int wcount = 0;
    int cyc = 0;
    logic [ADDR_W-1:0]   last_addr = '0;
    logic [DATA_W/8-1:0] last_strb = '0;

    always #4 clk = ~clk;

    tbuf_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tbuf_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_limit_pg(cfg_limit_pg),
        .cfg_buf_mode(cfg_buf_mode), .cfg_trg_mode(cfg_trg_mode),
        .cfg_en_self(cfg_en_self), .cfg_en_ext(cfg_en_ext), .self_hosted(self_hosted),
        .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .irq_clr(irq_clr), .trigger(trigger),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .m_valid(m_valid),
        .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data), .m_strb(m_strb),
        .irq_status(irq_status)
    );

    // Write monitor: records each completed memory write.
    always @(posedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            wcount    <= wcount + 1;
            last_addr <= m_addr;
            last_strb <= m_strb;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks + 1, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Offer one word; return after the edge that consumed it.
    task automatic send(input logic [DATA_W-1:0] w);
        logic r;
        s_valid = 1'b1;
        s_data  = w;
        forever begin
            r = s_ready;
            @(negedge clk);
            if (r) break;
        end
        s_valid = 1'b0;
    endtask

    task automatic pulse_trigger();
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
    endtask

    task automatic restart(input logic [ADDR_W-1:0] p);
        irq_clr   = 1'b1;
        ptr_wr    = 1'b1;
        ptr_wdata = p;
        @(negedge clk);
        irq_clr = 1'b0;
        ptr_wr  = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  bm;
        logic [15:0] start;
        logic [3:0]  beats;
        logic [3:0]  exp_w;
        logic [15:0] exp_last;
        logic        exp_irq;
    } vec_t;

    // Region 0x1000..0x1FFF, 8-byte words.
    localparam vec_t VECS [5] = '{
        '{2'b00, 16'h1FF0, 4'd4, 4'd2, 16'h1FF8, 1'b1},
        '{2'b01, 16'h1FF0, 4'd4, 4'd4, 16'h1008, 1'b1},
        '{2'b11, 16'h1FF0, 4'd4, 4'd4, 16'h1008, 1'b0},
        '{2'b10, 16'h1FF0, 4'd4, 4'd2, 16'h1FF8, 1'b1},
        '{2'b11, 16'h1000, 4'd3, 4'd3, 16'h1010, 1'b0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R5 R4 fill";
            1: return "R6 R4 wrap";
            2: return "R7 R4 circular";
            3: return "R11 reserved buffer mode";
            default: return "R3 linear";
        endcase
    endfunction

    int base_w;

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state, unit disabled (R2)
        check("R2 reset s_ready", 64'(s_ready), 64'd1);
        check("R12 reset irq", 64'(irq_status), 64'd0);
        check("R3 reset m_valid", 64'(m_valid), 64'd0);

        self_hosted = 1'b1;
        cfg_en_self = 1'b1;
        for (int i = 0; i < 5; i++) begin
            cfg_buf_mode = VECS[i].bm;
            cfg_trg_mode = 2'b11;
            restart(64'(VECS[i].start));
            base_w = wcount;
            for (int b = 0; b < int'(VECS[i].beats); b++) send(64'hA000 + 64'(b));
            idle(3);
            check({vec_tag(i), " writes"}, 64'(wcount - base_w), 64'(VECS[i].exp_w));
            check({vec_tag(i), " last addr"}, last_addr, 64'(VECS[i].exp_last));
            check({vec_tag(i), " irq"}, 64'(irq_status), 64'(VECS[i].exp_irq));
        end
        check("R3 strobe all ones", 64'(last_strb), 64'hFF);

        // R1 / R2 / R13: enable source select
        cfg_buf_mode = 2'b11;
        restart(64'h1000);
        self_hosted = 1'b0; cfg_en_self = 1'b1; cfg_en_ext = 1'b0;
        base_w = wcount;
        send(64'h11);
        idle(3);
        check("R1 R2 ext ctx, self bit ignored", 64'(wcount - base_w), 64'd0);
        cfg_en_ext = 1'b1;
        send(64'h12);
        idle(3);
        check("R1 ext ctx enabled", 64'(wcount - base_w), 64'd1);
        check("R13 loaded pointer used", last_addr, 64'h1000);
        self_hosted = 1'b1; cfg_en_self = 1'b0;
        send(64'h13);
        idle(3);
        check("R1 self ctx, ext bit ignored", 64'(wcount - base_w), 64'd1);

        // R8 / R14: stop trigger flushes the pending word first
        cfg_en_self = 1'b1;
        cfg_trg_mode = 2'b00;
        m_ready = 1'b0;
        send(64'h21);
        pulse_trigger();
        check("R8 irq waits for flush", 64'(irq_status), 64'd0);
        check("R14 pending write held", 64'(m_valid), 64'd1);
        idle(2);
        check("R14 address stable", m_addr, 64'h1008);
        check("R14 data stable", m_data, 64'h21);
        base_w = wcount;
        m_ready = 1'b1;
        @(negedge clk);
        check("R8 pending word flushed", 64'(wcount - base_w), 64'd1);
        check("R8 irq after flush", 64'(irq_status), 64'd1);
        send(64'h22);
        idle(3);
        check("R8 stopped discards", 64'(wcount - base_w), 64'd1);
        check("R12 irq sticky", 64'(irq_status), 64'd1);

        // R12: clear releases the stop
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check("R12 irq cleared", 64'(irq_status), 64'd0);
        send(64'h23);
        idle(3);
        check("R12 collection resumed", 64'(wcount - base_w), 64'd2);

        // R9: interrupt trigger
        cfg_trg_mode = 2'b01;
        pulse_trigger();
        check("R9 irq on trigger", 64'(irq_status), 64'd1);
        send(64'h24);
        idle(3);
        check("R9 collection continues", 64'(wcount - base_w), 64'd3);

        // R10: ignored trigger
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        cfg_trg_mode = 2'b11;
        pulse_trigger();
        idle(1);
        check("R10 irq unchanged", 64'(irq_status), 64'd0);
        send(64'h25);
        idle(3);
        check("R10 collection continues", 64'(wcount - base_w), 64'd4);

        // R11: reserved trigger encoding stops like 2'b00
        cfg_trg_mode = 2'b10;
        pulse_trigger();
        idle(2);
        check("R11 reserved trigger irq", 64'(irq_status), 64'd1);
        send(64'h26);
        idle(3);
        check("R11 reserved trigger stops", 64'(wcount - base_w), 64'd4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule